// File: doc/BRIEF.md
# Token Packet Field Decoder

This block sits behind the serial receive path of a low- and full-speed serial bus host or device. The line decoder and stuff-bit remover hand it packet bytes that are already assembled LSB-first. A start marker travels with the first byte, and an end marker follows the last byte or comes in the same cycle as it. The block checks the packet identifier (PID) in the first byte and sorts the packet into a class. For token packets it splits the 16-bit body into a 7-bit address, a 4-bit endpoint and a 5-bit CRC. For start-of-frame packets it splits the same body into an 11-bit frame number and the CRC. For both it checks the CRC and the packet length. Data, handshake and special packets only have their PID classified.

One result is issued per packet, on a single-cycle strobe in the cycle after the end marker is sampled. The strobe carries the class, the PID code nibble, the extracted fields and three independent error flags. It also carries a flag for a SETUP token addressed to endpoint 0, which is the control endpoint used to bring a device up.

The control is a two-state machine. `S_IDLE` means no packet is open. `S_BODY` means a packet is being collected. The transitions are:
- **IDLE_OPEN**: `S_IDLE` to `S_BODY` on a start byte with no end marker.
- **IDLE_SHOT**: stays in `S_IDLE`. A start byte arrives together with the end marker, and a one-byte packet result is issued.
- **BODY_CLOSE**: `S_BODY` to `S_IDLE` on the end marker.
- **BODY_RESTART**: stays in `S_BODY`. A new start byte arrives, and the packet collected so far is thrown away.
- **HOLD**: every other case keeps the current state.

Top module: `tok_pkt_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_vld` is 0 and every result output is 0.
- R2: A PID byte is accepted only if its upper nibble is the bitwise complement of its lower nibble and its lower nibble is one of 1, 9, 5, D, 2, A, E, C, 3 or B. Any other PID byte sets `res_pid_err` and gives class 7. In that case `res_len_err`, `res_crc_err` and `res_setup0` are 0.
- R3: The class code is set by the PID byte:
  - E1h gives 0 (OUT token).
  - 69h gives 1 (IN token).
  - 2Dh gives 2 (SETUP token).
  - A5h gives 3 (start of frame).
  - C3h and 4Bh give 4 (data).
  - D2h, 5Ah and 1Eh give 5 (handshake).
  - 3Ch gives 6 (special).
- R4: For class 0 to 2, `res_addr` is bits 6:0 of byte 1. `res_endp` is bits 2:0 of byte 2 above bit 7 of byte 1. For all other classes both are 0.
- R5: For class 3, `res_frame` is bits 2:0 of byte 2 above byte 1. For all other classes it is 0.
- R6: The CRC check works as follows:
  - A shift register preset to 11111b takes the 11 body bits, bit 0 of byte 1 first. Each step XORs the incoming bit with the register MSB, shifts the register left, and applies polynomial 00101b when that XOR is 1.
  - At the end the register is inverted.
  - Bits 7:3 of byte 2 must hold this result with its MSB in bit 3.
  - A mismatch in a 3-byte class 0 to 3 packet sets `res_crc_err`.
- R7: A class 0 to 3 packet with a byte count other than 3 sets `res_len_err`, with `res_crc_err` and `res_setup0` at 0. Bytes beyond the third do not alter the fields.
- R8: `res_setup0` is 1 exactly for a 3-byte SETUP token whose endpoint field is 0. The CRC result does not affect it.
- R9: `res_vld` pulses for one cycle, in the cycle after an end marker that closes an open packet. An end marker with no packet open produces nothing. A byte sampled together with the end marker belongs to the packet.
- R10: A start byte arriving while a packet is open restarts collection, and only the bytes from the new start count.
- R11: For class 4 to 6 no length or CRC check is made. `res_pid` always carries the lower nibble of the PID byte.
- R12: In every cycle where `res_vld` is 0, all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | A packet byte is present on `in_data` |
| in_sop | input | 1 | Start marker; meaningful only with `in_vld` |
| in_data | input | 8 | Packet byte, LSB-first assembled |
| in_eop | input | 1 | End marker for the open packet |
| res_vld | output | 1 | One-cycle result strobe |
| res_kind | output | 3 | Packet class code (R3) |
| res_pid | output | 4 | PID code nibble |
| res_addr | output | 7 | Token address |
| res_endp | output | 4 | Token endpoint |
| res_frame | output | 11 | Start-of-frame number |
| res_pid_err | output | 1 | PID rejected |
| res_crc_err | output | 1 | Body CRC mismatch |
| res_len_err | output | 1 | Token or frame packet not 3 bytes |
| res_setup0 | output | 1 | SETUP token to endpoint 0 |

## Verification
Two functions can fall in the same cycle: accepting the last packet byte and closing the packet. The bench sends many packets with the final byte and the end marker merged into one cycle. It sends the rest with the end marker in its own cycle, sometimes after idle gaps. Both forms must give identical fields and flags. The same-cycle start-and-end case is judged as a one-byte packet. A restart that lands on an open packet is judged only on the bytes that follow it.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic [2:0] {
        K_OUT     = 3'd0,
        K_IN      = 3'd1,
        K_SETUP   = 3'd2,
        K_SOF     = 3'd3,
        K_DATA    = 3'd4,
        K_HSHAKE  = 3'd5,
        K_SPECIAL = 3'd6,
        K_BAD     = 3'd7
    } kind_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_BODY = 1'b1
    } state_t;

endpackage

// File: rtl/tpd_pid_class.sv
module tpd_pid_class
    import tpd_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int NIB_W = BYTE_W / 2
) (
    input  logic [BYTE_W-1:0] pid_byte,
    output kind_t             kind,
    output logic              pid_ok
);

    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;
    logic             compl_ok;
    kind_t            raw_kind;

    assign lo_nib   = pid_byte[NIB_W-1:0];
    assign hi_nib   = pid_byte[BYTE_W-1:NIB_W];
    assign compl_ok = (hi_nib == ~lo_nib);

    always_comb begin
        unique case (lo_nib)
            4'h1:                 raw_kind = K_OUT;
            4'h9:                 raw_kind = K_IN;
            4'hD:                 raw_kind = K_SETUP;
            4'h5:                 raw_kind = K_SOF;
            4'h3, 4'hB:           raw_kind = K_DATA;
            4'h2, 4'hA, 4'hE:     raw_kind = K_HSHAKE;
            4'hC:                 raw_kind = K_SPECIAL;
            default:              raw_kind = K_BAD;
        endcase
    end

    assign pid_ok = compl_ok && (raw_kind != K_BAD);
    assign kind   = pid_ok ? raw_kind : K_BAD;

endmodule

// File: rtl/tpd_crc5.sv
module tpd_crc5 #(
    parameter int              BODY_W = 11,
    parameter int              CRC_W  = 5,
    parameter logic [CRC_W-1:0] POLY  = 5'h05
) (
    input  logic [BODY_W-1:0] body,
    output logic [CRC_W-1:0]  field
);

    logic [CRC_W-1:0] lfsr;
    logic [CRC_W-1:0] resid;

    always_comb begin
        logic fb;
        lfsr = '1;
        for (int i = 0; i < BODY_W; i++) begin
            fb   = body[i] ^ lfsr[CRC_W-1];
            lfsr = {lfsr[CRC_W-2:0], 1'b0};
            if (fb) begin
                lfsr = lfsr ^ POLY;
            end
        end
        resid = ~lfsr;
    end

    // the field carries the residue MSB in its lowest bit position
    generate
        for (genvar k = 0; k < CRC_W; k++) begin : g_rev
            assign field[k] = resid[CRC_W-1-k];
        end
    endgenerate

endmodule

// File: rtl/tpd_capture.sv
module tpd_capture #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_first,
    input  logic              take_more,
    input  logic [BYTE_W-1:0] data,
    output logic [BYTE_W-1:0] nxt_pid,
    output logic [BYTE_W-1:0] nxt_b1,
    output logic [BYTE_W-1:0] nxt_b2,
    output logic [CNT_W-1:0]  nxt_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BYTE_W-1:0] pid_q, b1_q, b2_q;
    logic [CNT_W-1:0]  cnt_q;

    always_comb begin
        nxt_pid = pid_q;
        nxt_b1  = b1_q;
        nxt_b2  = b2_q;
        nxt_cnt = cnt_q;
        if (take_first) begin
            nxt_pid = data;
            nxt_b1  = '0;
            nxt_b2  = '0;
            nxt_cnt = CNT_W'(1);
        end else if (take_more) begin
            if (cnt_q == CNT_W'(1)) nxt_b1 = data;
            if (cnt_q == CNT_W'(2)) nxt_b2 = data;
            if (cnt_q != CNT_MAX)   nxt_cnt = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_q <= '0;
            b1_q  <= '0;
            b2_q  <= '0;
            cnt_q <= '0;
        end else begin
            pid_q <= nxt_pid;
            b1_q  <= nxt_b1;
            b2_q  <= nxt_b2;
            cnt_q <= nxt_cnt;
        end
    end

    // R10: a start byte always restarts the count at one
    a_r10_restart_count : assert property (@(posedge clk) disable iff (!rst_n)
        take_first |=> (cnt_q == CNT_W'(1)));

    // R7: counter saturates instead of wrapping
    a_r7_count_saturates : assert property (@(posedge clk) disable iff (!rst_n)
        (take_more && !take_first && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/tok_pkt_decoder.sv
module tok_pkt_decoder
    import tpd_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 7,
    parameter int ENDP_W  = 4,
    parameter int CRC_W   = 5,
    parameter int TOK_LEN = 3,
    parameter int CNT_W   = 3,
    localparam int BODY_W = ADDR_W + ENDP_W,
    localparam int NIB_W  = BYTE_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sop,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_eop,
    output logic              res_vld,
    output logic [2:0]        res_kind,
    output logic [NIB_W-1:0]  res_pid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [ENDP_W-1:0] res_endp,
    output logic [BODY_W-1:0] res_frame,
    output logic              res_pid_err,
    output logic              res_crc_err,
    output logic              res_len_err,
    output logic              res_setup0
);

    state_t state_q, state_d;

    logic take_first, take_more, finish;

    logic [BYTE_W-1:0] nxt_pid, nxt_b1, nxt_b2;
    logic [CNT_W-1:0]  nxt_cnt;
    logic [2*BYTE_W-1:0] body16;
    logic [BODY_W-1:0]   body;
    logic [CRC_W-1:0]    rx_crc, calc_crc;

    kind_t kind;
    logic  pid_ok, is_tok, is_sof, len_ok, crc_bad;
    logic [ENDP_W-1:0] endp_w;

    // ---------------- input qualification ----------------
    assign take_first = in_vld && in_sop;
    assign take_more  = in_vld && !in_sop && (state_q == S_BODY);
    assign finish     = in_eop && (take_first || state_q == S_BODY);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take_first && !in_eop) state_d = S_BODY;  // IDLE_OPEN
                // IDLE_SHOT and HOLD stay in S_IDLE
            end
            S_BODY: begin
                if (in_eop) state_d = S_IDLE;                 // BODY_CLOSE
                // BODY_RESTART and HOLD stay in S_BODY
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    tpd_capture #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_first (take_first),
        .take_more  (take_more),
        .data       (in_data),
        .nxt_pid    (nxt_pid),
        .nxt_b1     (nxt_b1),
        .nxt_b2     (nxt_b2),
        .nxt_cnt    (nxt_cnt)
    );

    tpd_pid_class #(.BYTE_W(BYTE_W)) u_pid (
        .pid_byte (nxt_pid),
        .kind     (kind),
        .pid_ok   (pid_ok)
    );

    assign body16 = {nxt_b2, nxt_b1};
    assign body   = body16[BODY_W-1:0];
    assign rx_crc = body16[BODY_W +: CRC_W];
    assign endp_w = body[ADDR_W +: ENDP_W];

    tpd_crc5 #(.BODY_W(BODY_W), .CRC_W(CRC_W)) u_crc (
        .body  (body),
        .field (calc_crc)
    );

    assign is_tok  = (kind == K_OUT) || (kind == K_IN) || (kind == K_SETUP);
    assign is_sof  = (kind == K_SOF);
    assign len_ok  = (nxt_cnt == CNT_W'(TOK_LEN));
    assign crc_bad = (rx_crc != calc_crc);

    // ---------------- result register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n || !finish) begin
            res_vld     <= 1'b0;
            res_kind    <= '0;
            res_pid     <= '0;
            res_addr    <= '0;
            res_endp    <= '0;
            res_frame   <= '0;
            res_pid_err <= 1'b0;
            res_crc_err <= 1'b0;
            res_len_err <= 1'b0;
            res_setup0  <= 1'b0;
        end else begin
            res_vld     <= 1'b1;
            res_kind    <= kind;
            res_pid     <= nxt_pid[NIB_W-1:0];
            res_addr    <= is_tok ? body[ADDR_W-1:0] : '0;
            res_endp    <= is_tok ? endp_w : '0;
            res_frame   <= is_sof ? body : '0;
            res_pid_err <= !pid_ok;
            res_len_err <= (is_tok || is_sof) && !len_ok;
            res_crc_err <= (is_tok || is_sof) && len_ok && crc_bad;
            res_setup0  <= (kind == K_SETUP) && len_ok && (endp_w == '0);
        end
    end

    // ---------------- assertions ----------------
    // R2: rejected PID carries the invalid class and no other error
    a_r2_pid_err_alone : assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_pid_err) |-> (res_kind == 3'd7 && !res_len_err && !res_crc_err && !res_setup0));

    // R7: a length error masks the CRC and setup flags
    a_r7_len_masks : assert property (@(posedge clk) disable iff (!rst_n)
        res_len_err |-> (res_vld && !res_crc_err && !res_setup0 && res_kind <= 3'd3));

    // R8: the setup flag only accompanies a SETUP token to endpoint 0
    a_r8_setup_ep0 : assert property (@(posedge clk) disable iff (!rst_n)
        res_setup0 |-> (res_kind == 3'd2 && res_endp == '0));

    // R9: a strobe is always caused by an end marker one cycle earlier
    a_r9_needs_end : assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(in_eop));

    // R9: an end marker with no packet open gives no strobe
    a_r9_idle_end_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (in_eop && !in_vld && state_q == S_IDLE) |=> !res_vld);

    // R11: data, handshake and special packets are never length or CRC checked
    a_r11_no_checks : assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind >= 3'd4 && res_kind <= 3'd6) |-> (!res_len_err && !res_crc_err));

    // R12: result outputs are quiet between strobes
    a_r12_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (res_kind == '0 && res_pid == '0 && res_addr == '0 && res_endp == '0
                      && res_frame == '0 && !res_pid_err && !res_crc_err && !res_len_err && !res_setup0));

endmodule

// File: tb/tok_pkt_decoder_bench.sv
`timescale 1ns/1ps
module tok_pkt_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        res_vld;
    logic [2:0]  res_kind;
    logic [3:0]  res_pid;
    logic [6:0]  res_addr;
    logic [3:0]  res_endp;
    logic [10:0] res_frame;
    logic        res_pid_err, res_crc_err, res_len_err, res_setup0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tok_pkt_decoder u_tok_pkt_decoder (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sop(in_sop),
        .in_data(in_data), .in_eop(in_eop), .res_vld(res_vld),
        .res_kind(res_kind), .res_pid(res_pid), .res_addr(res_addr),
        .res_endp(res_endp), .res_frame(res_frame), .res_pid_err(res_pid_err),
        .res_crc_err(res_crc_err), .res_len_err(res_len_err), .res_setup0(res_setup0)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // spec CRC of the 11 body bits, returned in field bit order
    function automatic logic [4:0] crc_field(input logic [10:0] b);
        logic [4:0] r = 5'h1f;
        logic [4:0] f;
        for (int i = 0; i < 11; i++) begin
            logic x = b[i] ^ r[4];
            r = {r[3:0], 1'b0} ^ (x ? 5'h05 : 5'h00);
        end
        r = ~r;
        for (int k = 0; k < 5; k++) f[k] = r[4-k];
        return f;
    endfunction

    function automatic logic [2:0] kind_of(input logic [7:0] p);
        case (p)
            8'hE1: return 3'd0;
            8'h69: return 3'd1;
            8'h2D: return 3'd2;
            8'hA5: return 3'd3;
            8'hC3, 8'h4B: return 3'd4;
            8'hD2, 8'h5A, 8'h1E: return 3'd5;
            8'h3C: return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    logic [7:0] pb [0:7];

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_quiet(input string tag);
        chk(tag, {res_vld, res_kind, res_pid, res_addr, res_endp, res_frame,
                  res_pid_err, res_crc_err, res_len_err, res_setup0}, 32'h0);
    endtask

    task automatic check_result(input int n);
        logic [2:0]  k  = kind_of(pb[0]);
        logic [7:0]  b1 = (n > 1) ? pb[1] : 8'h00;
        logic [7:0]  b2 = (n > 2) ? pb[2] : 8'h00;
        logic [10:0] body = {b2[2:0], b1};
        bit tok = (k <= 3'd2);
        bit tf  = (k <= 3'd3);
        bit lok = (n == 3);
        chk("R9 strobe", res_vld, 1'b1);
        chk("R3 kind", res_kind, k);
        chk("R11 pid nibble", res_pid, pb[0][3:0]);
        chk("R2 pid_err", res_pid_err, k == 3'd7);
        chk("R4 addr", res_addr, tok ? body[6:0] : 7'd0);
        chk("R4 endp", res_endp, tok ? body[10:7] : 4'd0);
        chk("R5 frame", res_frame, (k == 3'd3) ? body : 11'd0);
        chk("R7 len_err", res_len_err, tf && !lok);
        chk("R6 crc_err", res_crc_err, tf && lok && (b2[7:3] != crc_field(body)));
        chk("R8 setup0", res_setup0, (k == 3'd2) && lok && (body[10:7] == 4'd0));
    endtask

    // send pb[0..n-1]; merge puts the end marker on the last byte
    task automatic send(input int n, input bit merge, input int gap);
        for (int i = 0; i < n; i++) begin
            in_vld = 1'b1; in_sop = (i == 0); in_data = pb[i];
            in_eop = merge && (i == n - 1);
            step();
            if (!(merge && i == n - 1)) chk("R9 no early strobe", res_vld, 1'b0);
        end
        in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        if (!merge) begin
            for (int g = 0; g < gap; g++) begin
                step();
                chk("R9 no strobe in gap", res_vld, 1'b0);
            end
            in_eop = 1'b1;
            step();
            in_eop = 1'b0;
        end
        check_result(n);
        step();
        check_quiet("R12 quiet after strobe");
    endtask

    task automatic build_token(input logic [7:0] pid, input logic [10:0] body, input bit bad_crc);
        logic [4:0] c = crc_field(body) ^ (bad_crc ? 5'h01 : 5'h00);
        pb[0] = pid;
        pb[1] = body[7:0];
        pb[2] = {c, body[10:8]};
        pb[3] = 8'h5A;
        pb[4] = 8'hC7;
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #1;
        check_quiet("R1 in reset");
        rst_n = 1'b1;
        step();
        check_quiet("R1 after reset");

        // directed: OUT token addr 5 endpoint 9, good CRC, end marker separate
        build_token(8'hE1, {4'd9, 7'd5}, 1'b0);
        send(3, 1'b0, 0);
        // R8: SETUP to endpoint 0, end marker merged
        build_token(8'h2D, {4'd0, 7'h33}, 1'b0);
        send(3, 1'b1, 0);
        // R8: SETUP to endpoint 0 with bad CRC still flags setup
        build_token(8'h2D, {4'd0, 7'h01}, 1'b1);
        send(3, 1'b1, 0);
        // R5: start of frame with max frame number
        build_token(8'hA5, 11'h7FF, 1'b0);
        send(3, 1'b0, 2);
        // R6: corrupted CRC on IN token
        build_token(8'h69, 11'h2AB, 1'b1);
        send(3, 1'b1, 0);
        // R7: short and long tokens
        build_token(8'h2D, 11'h000, 1'b0);
        send(2, 1'b1, 0);
        build_token(8'hA5, 11'h123, 1'b0);
        send(5, 1'b0, 1);
        // R2: complement ok but unlisted, and complement broken
        pb[0] = 8'hF0; send(1, 1'b1, 0);
        pb[0] = 8'hE2; pb[1] = 8'h00; pb[2] = 8'h00; send(3, 1'b0, 0);
        // R11: data and handshake
        pb[0] = 8'hC3; pb[1] = 8'h11; send(2, 1'b1, 0);
        pb[0] = 8'h1E; send(1, 1'b0, 0);
        pb[0] = 8'h3C; send(4, 1'b1, 0);

        // R9: end marker with nothing open
        in_eop = 1'b1; step(); in_eop = 1'b0;
        chk("R9 idle end ignored", res_vld, 1'b0);
        step();
        chk("R9 idle end ignored later", res_vld, 1'b0);

        // R10: restart mid-packet; only the new bytes count
        in_vld = 1'b1; in_sop = 1'b1; in_data = 8'h69; step();
        in_sop = 1'b0; in_data = 8'hFF; step();
        chk("R10 no strobe on open", res_vld, 1'b0);
        build_token(8'hE1, {4'd3, 7'h7E}, 1'b0);
        send(3, 1'b0, 0);

        // random mix
        for (int t = 0; t < 400; t++) begin
            int cls = $urandom_range(0, 7);
            int n = 3;
            logic [7:0] tokp [0:3] = '{8'hE1, 8'h69, 8'h2D, 8'hA5};
            logic [7:0] other [0:5] = '{8'hC3, 8'h4B, 8'hD2, 8'h5A, 8'h1E, 8'h3C};
            if (cls < 4) begin
                build_token(tokp[cls], 11'($urandom), ($urandom_range(0, 3) == 0));
                if ($urandom_range(0, 5) == 0) n = $urandom_range(1, 5);
                if (cls == 2 && $urandom_range(0, 2) == 0) pb[2][2:0] = 3'd0;
                if (cls == 2 && $urandom_range(0, 2) == 0) pb[1][7] = 1'b0;
            end else begin
                for (int j = 0; j < 8; j++) pb[j] = 8'($urandom);
                if (cls < 7) pb[0] = other[$urandom_range(0, 5)];
                n = $urandom_range(1, 6);
            end
            send(n, $urandom_range(0, 1) == 1, $urandom_range(0, 2));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule